// File: doc/BRIEF.md
# Eight-Channel Charge Converter Readout Sequencer

This block is the master-side controller for an integrating charge converter with eight input channels and a single serial data output. After the system reset ends it keeps the converter in reset and its configuration pins at zero for a settling interval. It then releases the converter, drives a fixed set of configuration levels, and starts a free-running master clock and a conversion toggle that alternates between the two integration phases.

The converter signals that a frame is ready by pulling an active-low ready line low. The sequencer synchronises that line and the serial data line. On each high-to-low transition of the ready line it issues 128 data-clock pulses at half the master clock rate and takes one bit on every falling edge. The frame arrives with channel 8 first and channel 1 last, each channel MSB first. The sequencer sorts the bits into eight 16-bit results, then presents all eight at once together with a one-cycle valid strobe. A ready transition that arrives while a frame is still being read sets a sticky overrun flag.

All timing is counted in system clock cycles: the master clock half-period, the conversion phase length and the settling delay are parameters.

Top module: `chgconv_readout`

## Requirements
- R1: After reset, `conv_rst_n_o` stays 0 and every configuration output stays 0 for `SETTLE_CYC` clock cycles. `conv_rst_n_o` reads 1 from the cycle after the `SETTLE_CYC`-th rising edge that follows the end of reset.
- R2: Once released, the configuration outputs hold these levels and never change until reset: `cfg_fmt_o`=0 (16-bit words), `cfg_rng_o`=3'b111, `cfg_hispd_o`=1, `cfg_clk4x_o`=0, `cfg_test_o`=1.
- R3: `mclk_o` is 0 while the converter is held in reset. After release it alternates with `MCLK_HALF` cycles high and `MCLK_HALF` cycles low.
- R4: `conv_o` is 0 while the converter is held in reset. After release each of its levels lasts exactly `CONV_HALF` cycles.
- R5: `dclk_o` idles low. During a frame each of its levels lasts 2*`MCLK_HALF` cycles, and exactly 128 falling edges are issued per frame.
- R6: A frame starts only on a high-to-low transition of `rdy_n_i` that is seen after release. Ready held low starts no second frame, and a low pulse during the settling interval starts none.
- R7: Bits 1 to 16 of a frame are channel 8, MSB first, and bits 113 to 128 are channel 1. Channel k appears on `ch_data_o[16*k-1 : 16*(k-1)]`. A bit is taken at the falling edge of `dclk_o`, and the converter may change `sdat_i` after that edge.
- R8: `frame_vld_o` is high for exactly one cycle after the 128th bit. `ch_data_o` changes only at that moment and holds its value until the next frame completes.
- R9: A high-to-low transition of `rdy_n_i` during a frame sets `overrun_o`, which stays 1 until reset. The frame in progress still completes with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_rst_n_o | output | 1 | Converter reset, active low |
| cfg_fmt_o | output | 1 | Output word format select (0 = 16 bit) |
| cfg_rng_o | output | 3 | Full-scale range select |
| cfg_hispd_o | output | 1 | High-speed / low-power select |
| cfg_clk4x_o | output | 1 | Master clock 4x divider select |
| cfg_test_o | output | 1 | Test-charge mode select |
| mclk_o | output | 1 | Converter master clock |
| conv_o | output | 1 | Integration phase toggle |
| dclk_o | output | 1 | Serial data clock |
| rdy_n_i | input | 1 | Data-ready from converter, active low |
| sdat_i | input | 1 | Serial data from converter |
| frame_vld_o | output | 1 | One-cycle strobe when a frame is complete |
| ch_data_o | output | 128 | Eight channel results, channel 1 in the low 16 bits |
| overrun_o | output | 1 | Sticky flag: ready seen again during a frame |

## Verification
A bit counter that is off by one shows at the ports within the first frame in two ways: the number of data-clock falling edges is not 128, and every channel value is shifted across channel boundaries. A reversed channel slot decode puts distinct per-channel patterns in mirrored positions as soon as `frame_vld_o` pulses. Stuck or miscounted timebase state shows within one master-clock or conversion period as a wrong level length. A missing edge detector shows as extra data-clock edges while ready is held low.

// File: rtl/chgconv_pkg.sv
// Package: shared sizes and the run-time configuration levels of the
// charge-converter readout sequencer. Assumes 16-bit output format only.
package chgconv_pkg;
    localparam int NCH        = 8;
    localparam int CH_W       = 16;
    localparam int FRAME_BITS = NCH * CH_W;

    typedef struct packed {
        logic       fmt;
        logic [2:0] rng;
        logic       hispd;
        logic       clk4x;
        logic       test;
    } cfg_t;

    localparam cfg_t CFG_RUN = '{fmt: 1'b0, rng: 3'b111, hispd: 1'b1,
                                 clk4x: 1'b0, test: 1'b1};
endpackage

// File: rtl/chgconv_powerup.sv
// Power-up sequencer: counts SETTLE_CYC cycles after reset and then raises
// released_o for good. Assumes SETTLE_CYC >= 1.
module chgconv_powerup #(
    parameter int SETTLE_CYC = 7_500_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic released_o
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          rel_q;

    // Count the settling interval, then latch the release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rel_q <= 1'b0;
        end else if (!rel_q) begin
            if (cnt_q == CW'(SETTLE_CYC - 1)) rel_q <= 1'b1;
            else                              cnt_q <= cnt_q + 1'b1;
        end
    end

    assign released_o = rel_q;

    // R1: once released, the converter stays out of reset
    a_r1_release_stays: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q |=> rel_q);
endmodule

// File: rtl/chgconv_timebase.sv
// Timebase: master clock (MCLK_HALF cycles per level) and conversion toggle
// (CONV_HALF cycles per level). Both sit low while run_i is 0. tick_o
// marks the cycle whose edge raises the master clock.
module chgconv_timebase #(
    parameter int MCLK_HALF = 1250,
    parameter int CONV_HALF = 125_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic mclk_o,
    output logic conv_o,
    output logic tick_o
);
    localparam int MW = $clog2(MCLK_HALF + 1);
    localparam int CW = $clog2(CONV_HALF + 1);

    logic [MW-1:0] mcnt_q;
    logic [CW-1:0] ccnt_q;
    logic          mclk_q, conv_q;
    logic          mwrap, cwrap;

    assign mwrap  = (mcnt_q == MW'(MCLK_HALF - 1));
    assign cwrap  = (ccnt_q == CW'(CONV_HALF - 1));
    assign tick_o = run_i && mwrap && !mclk_q;

    // Master clock divider.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            mcnt_q <= '0;
            mclk_q <= 1'b0;
        end else if (mwrap) begin
            mcnt_q <= '0;
            mclk_q <= ~mclk_q;
        end else begin
            mcnt_q <= mcnt_q + 1'b1;
        end
    end

    // Conversion phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            ccnt_q <= '0;
            conv_q <= 1'b0;
        end else if (cwrap) begin
            ccnt_q <= '0;
            conv_q <= ~conv_q;
        end else begin
            ccnt_q <= ccnt_q + 1'b1;
        end
    end

    assign mclk_o = mclk_q;
    assign conv_o = conv_q;

    // R3/R4: both outputs are quiet one cycle after run is low
    a_r4_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!mclk_q && !conv_q));
    // R3: master clock counter never passes its limit
    a_r3_mcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mcnt_q < MW'(MCLK_HALF));
endmodule

// File: rtl/chgconv_frame_rx.sv
// Frame receiver: synchronises ready and data, starts a frame on a falling
// ready edge, toggles the data clock on each master clock tick, takes a bit
// on every data clock fall and routes it to its channel (highest channel
// first, MSB first). Assumes sdat_i is stable for 2 cycles before a fall.
module chgconv_frame_rx
    import chgconv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic                  tick_i,
    input  logic                  rdy_n_i,
    input  logic                  sdat_i,
    output logic                  dclk_o,
    output logic                  vld_o,
    output logic [FRAME_BITS-1:0] data_o,
    output logic                  ovr_o
);
    localparam int BW = $clog2(FRAME_BITS + 1);
    localparam int PW = $clog2(CH_W);

    logic          rdy_m, rdy_s, rdy_d, sdat_m, sdat_s;
    logic          busy_q, dclk_q, vld_q, ovr_q;
    logic [BW-1:0] bit_cnt;
    logic [BW-1:0] slot;
    logic [PW-1:0] bpos;
    logic          rdy_fall, cap_en, fin;

    // Two-flop synchronisers plus an edge register on ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_m <= 1'b1; rdy_s <= 1'b1; rdy_d <= 1'b1;
            sdat_m <= 1'b0; sdat_s <= 1'b0;
        end else begin
            rdy_m <= rdy_n_i; rdy_s <= rdy_m; rdy_d <= rdy_s;
            sdat_m <= sdat_i; sdat_s <= sdat_m;
        end
    end

    assign rdy_fall = rdy_d && !rdy_s;
    assign cap_en   = busy_q && tick_i && dclk_q;
    assign fin      = cap_en && (bit_cnt == BW'(FRAME_BITS - 1));
    assign slot     = bit_cnt / BW'(CH_W);
    assign bpos     = PW'(CH_W - 1) - PW'(bit_cnt % BW'(CH_W));

    // Frame control: start, data clock, bit count, strobe and overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            dclk_q  <= 1'b0;
            vld_q   <= 1'b0;
            ovr_q   <= 1'b0;
            bit_cnt <= '0;
        end else begin
            vld_q <= fin;
            if (busy_q && rdy_fall) ovr_q <= 1'b1;
            if (!busy_q) begin
                bit_cnt <= '0;
                if (run_i && rdy_fall) busy_q <= 1'b1;
            end else if (tick_i) begin
                dclk_q <= ~dclk_q;
                if (dclk_q) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (fin) busy_q <= 1'b0;
                end
            end
        end
    end

    // One working and one output register per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int SLOT = NCH - 1 - c;
        logic [CH_W-1:0] work_q, work_nxt, out_q;

        // Place the incoming bit when this channel's slot is on the wire.
        always_comb begin
            work_nxt = work_q;
            if (cap_en && slot == BW'(SLOT)) work_nxt[bpos] = sdat_s;
        end

        // Hold the working value; publish it at frame end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                work_q <= '0;
                out_q  <= '0;
            end else begin
                work_q <= work_nxt;
                if (fin) out_q <= work_nxt;
            end
        end

        assign data_o[c*CH_W +: CH_W] = out_q;
    end

    assign dclk_o = dclk_q;
    assign vld_o  = vld_q;
    assign ovr_o  = ovr_q;

    // R5: data clock is low whenever no frame is in progress
    a_r5_dclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !dclk_q);
    // R5: bit count stays inside one frame
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> bit_cnt < BW'(FRAME_BITS));
    // R6: no frame before release
    a_r6_no_start_before_run: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !busy_q);
    // R8: valid strobe lasts a single cycle
    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);
    // R8: results change only with the strobe
    a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_q |-> $stable(data_o));
    // R9: overrun is sticky
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> ovr_q);
endmodule

// File: rtl/chgconv_readout.sv
// Top: charge-converter readout sequencer. Ties the power-up sequencer, the
// timebase and the frame receiver together and drives the static
// configuration levels once the converter is released.
module chgconv_readout
    import chgconv_pkg::*;
#(
    parameter int MCLK_HALF  = 1250,
    parameter int CONV_HALF  = 125_000,
    parameter int SETTLE_CYC = 7_500_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic                  conv_rst_n_o,
    output logic                  cfg_fmt_o,
    output logic [2:0]            cfg_rng_o,
    output logic                  cfg_hispd_o,
    output logic                  cfg_clk4x_o,
    output logic                  cfg_test_o,
    output logic                  mclk_o,
    output logic                  conv_o,
    output logic                  dclk_o,
    input  logic                  rdy_n_i,
    input  logic                  sdat_i,
    output logic                  frame_vld_o,
    output logic [FRAME_BITS-1:0] ch_data_o,
    output logic                  overrun_o
);
    logic released, tick;
    cfg_t cfg;

    chgconv_powerup #(.SETTLE_CYC(SETTLE_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_n), .released_o(released));

    chgconv_timebase #(.MCLK_HALF(MCLK_HALF), .CONV_HALF(CONV_HALF)) u_tb (
        .clk(clk), .rst_n(rst_n), .run_i(released),
        .mclk_o(mclk_o), .conv_o(conv_o), .tick_o(tick));

    chgconv_frame_rx u_rx (
        .clk(clk), .rst_n(rst_n), .run_i(released), .tick_i(tick),
        .rdy_n_i(rdy_n_i), .sdat_i(sdat_i), .dclk_o(dclk_o),
        .vld_o(frame_vld_o), .data_o(ch_data_o), .ovr_o(overrun_o));

    assign cfg          = released ? CFG_RUN : '0;
    assign conv_rst_n_o = released;
    assign cfg_fmt_o    = cfg.fmt;
    assign cfg_rng_o    = cfg.rng;
    assign cfg_hispd_o  = cfg.hispd;
    assign cfg_clk4x_o  = cfg.clk4x;
    assign cfg_test_o   = cfg.test;

    // R3: all clocks quiet while the converter is in reset
    a_r3_clocks_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_rst_n_o |-> (!mclk_o && !conv_o && !dclk_o));
    // R2: configuration frozen after release
    a_r2_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        conv_rst_n_o |=> ($stable(cfg_rng_o) && $stable(cfg_test_o) && $stable(cfg_hispd_o)));
endmodule

// File: tb/chgconv_readout_tb.sv
`timescale 1ns/1ps
module chgconv_readout_tb_top;
    localparam int MH = 3, CH = 100, ST = 50;

    logic clk = 1'b0, rst_n = 1'b0, rdy_n = 1'b1;
    logic conv_rst_n, fmt, hispd, clk4x, tst, mclk, conv, dclk, vld, ovr, sdat;
    logic [2:0]   rng;
    logic [127:0] chd, frame_bits;
    int checks = 0, fails = 0, falls = 0, base = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    chgconv_readout #(.MCLK_HALF(MH), .CONV_HALF(CH), .SETTLE_CYC(ST)) dut_i (
        .clk(clk), .rst_n(rst_n), .conv_rst_n_o(conv_rst_n), .cfg_fmt_o(fmt),
        .cfg_rng_o(rng), .cfg_hispd_o(hispd), .cfg_clk4x_o(clk4x), .cfg_test_o(tst),
        .mclk_o(mclk), .conv_o(conv), .dclk_o(dclk), .rdy_n_i(rdy_n), .sdat_i(sdat),
        .frame_vld_o(vld), .ch_data_o(chd), .overrun_o(ovr));

    // Converter model: counts data clock falls, shifts the frame MSB first.
    always @(negedge dclk) falls++;
    always_comb begin
        int k;
        k = falls - base;
        sdat = (k >= 0 && k < 128) ? frame_bits[127 - k] : 1'b0;
    end

    // base pattern / per-channel step: channel c value = base ^ (step*c)
    localparam logic [31:0] VEC [4] = '{32'h0000_0000, 32'hFFFF_0000,
                                        32'hA5C3_1111, 32'h0001_0102};

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] build(input logic [31:0] v);
        logic [127:0] b;
        for (int c = 1; c <= 8; c++) b[16*(c-1) +: 16] = v[31:16] ^ 16'(v[15:0] * c);
        return b;
    endfunction

    // One frame: ready low, optional mid-frame ready pulse, wait for strobe.
    task automatic run_frame(input logic [127:0] bits, input bit glitch);
        int n = 0;
        frame_bits = bits;
        base = falls;
        @(negedge clk) rdy_n = 1'b0;
        if (glitch) begin
            repeat (300) @(negedge clk);
            rdy_n = 1'b1;
            repeat (5) @(negedge clk);
            rdy_n = 1'b0;
        end
        while (!vld && n < 5000) begin @(negedge clk); n++; end
        check(vld, "R8 strobe seen", {127'd0, vld}, 128'd1);
        check(chd == bits, "R7 channel data", chd, bits);
        check(falls - base == 128, "R5 falling edges", 128'(falls - base), 128'd128);
        @(negedge clk);
        check(!vld, "R8 strobe one cycle", {127'd0, vld}, 128'd0);
        rdy_n = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rdy_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int n;
        frame_bits = '0;
        repeat (3) @(negedge clk);
        check(!conv_rst_n && !mclk && !dclk && !vld && !ovr, "R1 reset state",
              {123'd0, conv_rst_n, mclk, dclk, vld, ovr}, 128'd0);
        rst_n = 1'b1;
        // R1 settling interval with an R6 ready pulse inside it
        for (int i = 1; i <= ST - 1; i++) begin
            @(negedge clk);
            rdy_n = !(i >= 5 && i < 12);
        end
        check(!conv_rst_n && {fmt, rng, hispd, clk4x, tst} == 7'd0, "R1 held during settle",
              {120'd0, conv_rst_n, fmt, rng, hispd, clk4x, tst}, 128'd0);
        @(negedge clk);
        check(conv_rst_n, "R1 release", {127'd0, conv_rst_n}, 128'd1);
        check({fmt, rng, hispd, clk4x, tst} == 7'b0_111_1_0_1, "R2 config levels",
              {121'd0, fmt, rng, hispd, clk4x, tst}, 128'b0111101);
        // R3 master clock level lengths
        while (!mclk) @(negedge clk);
        n = 0; while (mclk)  begin @(negedge clk); n++; end
        check(n == MH, "R3 mclk high", 128'(n), 128'(MH));
        n = 0; while (!mclk) begin @(negedge clk); n++; end
        check(n == MH, "R3 mclk low", 128'(n), 128'(MH));
        // R4 conversion phase length
        while (!conv) @(negedge clk);
        n = 0; while (conv) begin @(negedge clk); n++; end
        check(n == CH, "R4 conv phase", 128'(n), 128'(CH));
        check(falls == 0, "R6 no frame from pulse during settle", 128'(falls), 128'd0);
        // Table walk
        foreach (VEC[i]) run_frame(build(VEC[i]), 1'b0);
        // R8 hold after strobe
        repeat (50) @(negedge clk);
        check(chd == build(VEC[3]), "R8 data held", chd, build(VEC[3]));
        // R6 ready held low starts one frame only
        frame_bits = build(32'h1234_0F0F);
        base = falls;
        rdy_n = 1'b0;
        repeat (4000) @(negedge clk);
        check(falls - base == 128, "R6 one frame while held low", 128'(falls - base), 128'd128);
        rdy_n = 1'b1;
        repeat (20) @(negedge clk);
        check(!ovr, "R9 no overrun yet", {127'd0, ovr}, 128'd0);
        // R9 overrun
        run_frame(build(32'h5A5A_0303), 1'b1);
        check(ovr, "R9 overrun set", {127'd0, ovr}, 128'd1);
        run_frame(build(32'hC001_0041), 1'b0);
        check(ovr, "R9 overrun sticky", {127'd0, ovr}, 128'd1);
        do_reset();
        @(negedge clk);
        check(!ovr && chd == '0, "R9 cleared by reset", {127'd0, ovr}, 128'd0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
        $finish;
    end

    initial begin
        #700us;
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
        $finish;
    end
endmodule